// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block tells a host how an embedded program or erase operation is going. The operation engine and the memory array sit outside it. The block watches the engine's busy, suspend and fault conditions and reports them in three ways at once.

The first is a polling word that replaces array data on reads while an operation is in progress. It carries a data-complement bit and two toggle bits, one of which toggles only within the sector being erased. The second is a status register word. It is captured when the host issues a status-read command and is returned by the next read at any address. The third is a ready/busy level.

The block also handles the clear-status and reset commands. It gives the two fault kinds different signatures. A protection fault holds the block busy for a fixed time with an invalid status word. A buffer abort holds the block busy with a valid status word until the host clears it.

Top module: `eop_status_report`

## Requirements
- R1: After reset, `rdy_o` is 1, `sr_word` is 0 and a read returns `dq_status_sel` = 0.
- R2: While the operation runs (`op_busy`=1, `op_suspended`=0), each read returns the polling word. Bit 6 of that word is the inverse of its value on the previous polling read, whatever the sector read. The first polling read after reset returns 0 in bit 6.
- R3: Bit 2 of the polling word inverts from one polling read to the next only when `op_is_erase`=1 and `rd_sector` equals `erase_sector`. Every other polling read returns bit 2 unchanged.
- R4: Polling bit 7 is the complement of `prog_d7` during a program and 0 during an erase. It is 1 on a read of the erase-suspended sector.
- R5: A `ev_tmo` pulse sets polling bit 5 and holds `rdy_o` low. It also sets status bit 5 for an erase or status bit 4 for a program. Only `cmd_reset` releases the hold. `cmd_status_clear` clears the status bit but leaves the hold in place.
- R6: A `ev_abort` pulse sets polling bit 1 and holds `rdy_o` low. The status word stays ready, with bit 7 = 1 and bits 4 and 3 = 1. `cmd_status_clear` or `cmd_reset` releases the hold.
- R7: A `ev_prot` pulse holds `rdy_o` low for exactly PROT_CYCLES cycles. During that time the live status word is 0x00. Afterwards status bit 1 reads 1.
- R8: `cmd_status_read` captures the live status word into `sr_word` on the next clock edge. The next read, at any sector, returns that word with `dq_status_sel` = 1. The read after it reverts to polling or array mode.
- R9: `cmd_status_clear` and `cmd_reset` clear status bits 5, 4, 3 and 1, both in the fault flags and in `sr_word`. Bits 7, 6 and 2 are left as they were.
- R10: If a capture and a clear fall in the same cycle, `sr_word` takes the word as it was before the clear, and the flags are still cleared. If a new fault event and a clear fall in the same cycle, the fault is kept.
- R11: While suspended, `rdy_o` is 1. Status bit 6 (erase suspended) or bit 2 (program suspended) is set. A read gives polling only in the erase-suspended sector, and there bit 6 of the polling word does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_busy | input | 1 | Embedded operation active |
| op_is_erase | input | 1 | 1 = erase, 0 = program |
| op_suspended | input | 1 | Operation suspended |
| ev_tmo | input | 1 | Pulse: pulse-count limit exceeded |
| ev_prot | input | 1 | Pulse: protected-area fault |
| ev_abort | input | 1 | Pulse: write-to-buffer abort |
| rd_strobe | input | 1 | Host read in this cycle |
| rd_sector | input | SECT_W | Sector field of the read address |
| erase_sector | input | SECT_W | Sector being erased or erase-suspended |
| prog_d7 | input | 1 | Bit 7 of the word being programmed |
| cmd_status_read | input | 1 | Status-read command (capture strobe) |
| cmd_status_clear | input | 1 | Clear-status command |
| cmd_reset | input | 1 | Reset command |
| dq_out | output | DATA_W | Status word for the data bus, valid the cycle after a read |
| dq_status_sel | output | 1 | 1 = drive `dq_out`, 0 = array data |
| sr_word | output | 8 | Captured status register |
| rdy_o | output | 1 | Ready (1) / busy (0) level |

## Verification
Two pairs of events can land in the same cycle. A status capture can coincide with a clear, and a fresh abort can coincide with a clear. The bench drives both commands in one cycle. It then checks two things: the captured word still holds the pre-clear fault bits, and the ready level shows the flags as cleared (or, in the second case, the abort as kept). A follow-up capture then confirms the flag state by itself. The toggle bits are swept over every pairing of read sector and erase sector, against a bench model of the two toggle states.

// File: rtl/eop_status_pkg.sv
package eop_status_pkg;
  // Status register bit positions (host software decodes these)
  localparam int SRB_READY = 7;
  localparam int SRB_ESUSP = 6;
  localparam int SRB_EFAIL = 5;
  localparam int SRB_PFAIL = 4;
  localparam int SRB_ABORT = 3;
  localparam int SRB_PSUSP = 2;
  localparam int SRB_LOCK  = 1;
  localparam logic [7:0] SR_CLR_MASK = 8'b0011_1010;

  typedef struct packed {
    logic efail;
    logic pfail;
    logic abort;
    logic lock;
  } eop_flags_t;
endpackage

// File: rtl/eop_err_track.sv
module eop_err_track
  import eop_status_pkg::*;
#(
  parameter int PROT_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_busy,
  input  logic       op_is_erase,
  input  logic       op_suspended,
  input  logic       ev_tmo,
  input  logic       ev_prot,
  input  logic       ev_abort,
  input  logic       cmd_clear,
  input  logic       cmd_reset,
  output logic       prot_busy,
  output logic       tmo_hold,
  output eop_flags_t flags,
  output logic [7:0] live_sr
);
  localparam int CNT_W = $clog2(PROT_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  eop_flags_t       flg_q, flg_d;
  logic             tmo_q, tmo_d;
  logic             ready;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else if (ev_prot) cnt_d = CNT_W'(PROT_CYCLES);

    flg_d = flg_q;
    if (cmd_clear || cmd_reset) flg_d = '0;
    if (ev_tmo) begin
      if (op_is_erase) flg_d.efail = 1'b1;
      else             flg_d.pfail = 1'b1;
    end
    if (ev_abort) begin
      flg_d.abort = 1'b1;
      flg_d.pfail = 1'b1;
    end
    if (ev_prot) flg_d.lock = 1'b1;

    tmo_d = tmo_q;
    if (cmd_reset) tmo_d = 1'b0;
    if (ev_tmo)    tmo_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flg_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      flg_q <= flg_d;
      tmo_q <= tmo_d;
    end
  end

  assign prot_busy = (cnt_q != '0);
  assign tmo_hold  = tmo_q;
  assign flags     = flg_q;
  assign ready     = !(op_busy && !op_suspended) && !prot_busy;

  always_comb begin
    live_sr = '0;
    if (ready) begin
      live_sr[SRB_READY] = 1'b1;
      live_sr[SRB_ESUSP] = op_suspended && op_is_erase;
      live_sr[SRB_EFAIL] = flg_q.efail;
      live_sr[SRB_PFAIL] = flg_q.pfail;
      live_sr[SRB_ABORT] = flg_q.abort;
      live_sr[SRB_PSUSP] = op_suspended && !op_is_erase;
      live_sr[SRB_LOCK]  = flg_q.lock;
    end
  end

  AST_PROT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_busy) |-> $past(ev_prot)); // R7
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q && !cmd_reset) |=> tmo_q); // R5
endmodule

// File: rtl/eop_poll_word.sv
module eop_poll_word #(
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [SECT_W-1:0] rd_sector,
  input  logic [SECT_W-1:0] erase_sector,
  input  logic              op_is_erase,
  input  logic              op_suspended,
  input  logic              prog_d7,
  input  logic              tmo_hold,
  input  logic              abort_hold,
  output logic              in_sector,
  output logic              susp_read,
  output logic [7:0]        poll
);
  logic t6_q, t6_d, t2_q, t2_d;

  assign in_sector = (rd_sector == erase_sector);
  assign susp_read = op_suspended && op_is_erase && in_sector;

  always_comb begin
    t6_d = t6_q ^ (take && !susp_read);
    t2_d = t2_q ^ (take && op_is_erase && in_sector);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t6_q <= 1'b0;
      t2_q <= 1'b0;
    end else begin
      t6_q <= t6_d;
      t2_q <= t2_d;
    end
  end

  always_comb begin
    poll    = '0;
    poll[7] = susp_read ? 1'b1 : (op_is_erase ? 1'b0 : !prog_d7);
    poll[6] = t6_q;
    poll[5] = tmo_hold;
    poll[2] = t2_q;
    poll[1] = abort_hold;
  end

  AST_DQ2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_sector) |=> (t2_q == $past(t2_q))); // R3
endmodule

// File: rtl/eop_sr_capture.sv
module eop_sr_capture
  import eop_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] live_sr,
  input  logic       cmd_status_read,
  input  logic       cmd_clear,
  input  logic       cmd_reset,
  input  logic       rd_take_sr,
  output logic       sr_mode,
  output logic [7:0] sr_cap
);
  logic [7:0] cap_q, cap_d;
  logic       mode_q, mode_d;

  always_comb begin
    cap_d = cap_q;
    if (cmd_status_read)            cap_d = live_sr;
    else if (cmd_clear || cmd_reset) cap_d = cap_q & ~SR_CLR_MASK;

    mode_d = mode_q;
    if (cmd_status_read)               mode_d = 1'b1;
    else if (cmd_reset || rd_take_sr)  mode_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      mode_q <= mode_d;
    end
  end

  assign sr_mode = mode_q;
  assign sr_cap  = cap_q;

  AST_BLANK_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_q[7] |-> (cap_q[6:0] == 7'd0)); // R7
  AST_CLEAR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_clear || cmd_reset) && !cmd_status_read) |=> ((cap_q & SR_CLR_MASK) == 8'd0)); // R9
endmodule

// File: rtl/eop_status_report.sv
module eop_status_report
  import eop_status_pkg::*;
#(
  parameter int SECT_W      = 3,
  parameter int DATA_W      = 16,
  parameter int PROT_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_busy,
  input  logic              op_is_erase,
  input  logic              op_suspended,
  input  logic              ev_tmo,
  input  logic              ev_prot,
  input  logic              ev_abort,
  input  logic              rd_strobe,
  input  logic [SECT_W-1:0] rd_sector,
  input  logic [SECT_W-1:0] erase_sector,
  input  logic              prog_d7,
  input  logic              cmd_status_read,
  input  logic              cmd_status_clear,
  input  logic              cmd_reset,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_status_sel,
  output logic [7:0]        sr_word,
  output logic              rdy_o
);
  localparam int PAD_W = DATA_W - 8;

  logic [1:0]  rs_q;
  logic        rst_i;
  logic        prot_busy, tmo_hold, in_sector, susp_read, sr_mode;
  eop_flags_t  flags;
  logic [7:0]  live_sr, poll, sr_cap;
  logic        running, overlay, take_sr, take_poll;
  logic [DATA_W-1:0] dq_q, dq_d;
  logic        sel_q, sel_d;

  // Reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  eop_err_track #(.PROT_CYCLES(PROT_CYCLES)) u_err (
    .clk(clk), .rst_n(rst_i), .op_busy(op_busy), .op_is_erase(op_is_erase),
    .op_suspended(op_suspended), .ev_tmo(ev_tmo), .ev_prot(ev_prot),
    .ev_abort(ev_abort), .cmd_clear(cmd_status_clear), .cmd_reset(cmd_reset),
    .prot_busy(prot_busy), .tmo_hold(tmo_hold), .flags(flags), .live_sr(live_sr)
  );

  eop_poll_word #(.SECT_W(SECT_W)) u_poll (
    .clk(clk), .rst_n(rst_i), .take(take_poll), .rd_sector(rd_sector),
    .erase_sector(erase_sector), .op_is_erase(op_is_erase),
    .op_suspended(op_suspended), .prog_d7(prog_d7), .tmo_hold(tmo_hold),
    .abort_hold(flags.abort), .in_sector(in_sector), .susp_read(susp_read),
    .poll(poll)
  );

  eop_sr_capture u_sr (
    .clk(clk), .rst_n(rst_i), .live_sr(live_sr), .cmd_status_read(cmd_status_read),
    .cmd_clear(cmd_status_clear), .cmd_reset(cmd_reset), .rd_take_sr(take_sr),
    .sr_mode(sr_mode), .sr_cap(sr_cap)
  );

  assign running   = op_busy && !op_suspended;
  assign overlay   = running || prot_busy || tmo_hold || flags.abort || susp_read;
  assign take_sr   = rd_strobe && sr_mode;
  assign take_poll = rd_strobe && !sr_mode && overlay;

  always_comb begin
    dq_d  = dq_q;
    sel_d = sel_q;
    if (rd_strobe) begin
      sel_d = take_sr || take_poll;
      if (take_sr)        dq_d = {{PAD_W{1'b0}}, sr_cap};
      else if (take_poll) dq_d = {{PAD_W{1'b0}}, poll};
      else                dq_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      dq_q  <= '0;
      sel_q <= 1'b0;
    end else begin
      dq_q  <= dq_d;
      sel_q <= sel_d;
    end
  end

  assign dq_out        = dq_q;
  assign dq_status_sel = sel_q;
  assign sr_word       = sr_cap;
  assign rdy_o         = !(running || prot_busy || tmo_hold || flags.abort);

  AST_FAULT_BUSY: assert property (@(posedge clk) disable iff (!rst_i)
    (tmo_hold || flags.abort) |-> !rdy_o); // R5
  AST_SUSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0({live_sr[SRB_ESUSP], live_sr[SRB_PSUSP]})); // R11
endmodule

// File: tb/test_eop_status_report.sv
module test_eop_status_report;
  localparam int SECT_W = 3;
  localparam int DATA_W = 16;
  localparam int PROTC  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_busy = 0, op_is_erase = 0, op_suspended = 0;
  logic ev_tmo = 0, ev_prot = 0, ev_abort = 0;
  logic rd_strobe = 0;
  logic [SECT_W-1:0] rd_sector = '0, erase_sector = '0;
  logic prog_d7 = 0;
  logic cmd_status_read = 0, cmd_status_clear = 0, cmd_reset = 0;
  logic [DATA_W-1:0] dq_out;
  logic dq_status_sel;
  logic [7:0] sr_word;
  logic rdy_o;

  int checks = 0, errors = 0;
  logic m_t6 = 0, m_t2 = 0, m_tmo = 0, m_abort = 0;

  always #4 clk = ~clk;

  eop_status_report #(.SECT_W(SECT_W), .DATA_W(DATA_W), .PROT_CYCLES(PROTC)) i_eop_status_report (
    .clk(clk), .rst_n(rst_n), .op_busy(op_busy), .op_is_erase(op_is_erase),
    .op_suspended(op_suspended), .ev_tmo(ev_tmo), .ev_prot(ev_prot), .ev_abort(ev_abort),
    .rd_strobe(rd_strobe), .rd_sector(rd_sector), .erase_sector(erase_sector),
    .prog_d7(prog_d7), .cmd_status_read(cmd_status_read),
    .cmd_status_clear(cmd_status_clear), .cmd_reset(cmd_reset),
    .dq_out(dq_out), .dq_status_sel(dq_status_sel), .sr_word(sr_word), .rdy_o(rdy_o)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // mask: {status_read, clear, reset, tmo, prot, abort}
  task automatic pulse(input logic [5:0] m);
    {cmd_status_read, cmd_status_clear, cmd_reset, ev_tmo, ev_prot, ev_abort} = m;
    @(negedge clk);
    {cmd_status_read, cmd_status_clear, cmd_reset, ev_tmo, ev_prot, ev_abort} = '0;
  endtask

  task automatic rd(input logic [SECT_W-1:0] s);
    rd_strobe = 1'b1;
    rd_sector = s;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic poll_chk(input logic [SECT_W-1:0] s, input string rq);
    logic in_s, srd, ov;
    logic [7:0] e;
    in_s = (s == erase_sector);
    srd  = op_suspended && op_is_erase && in_s;
    ov   = (op_busy && !op_suspended) || m_tmo || m_abort || srd;
    e = {srd ? 1'b1 : (op_is_erase ? 1'b0 : !prog_d7), m_t6, m_tmo, 2'b00, m_t2, m_abort, 1'b0};
    rd(s);
    chk({rq, " sel"}, 32'(dq_status_sel), 32'(ov));
    if (ov) begin
      chk({rq, " poll"}, 32'(dq_out), 32'(e));
      if (!srd) m_t6 = !m_t6;
      if (op_is_erase && in_s) m_t2 = !m_t2;
    end
  endtask

  task automatic sr_rd_chk(input logic [7:0] exp, input string rq);
    chk({rq, " sr_word"}, 32'(sr_word), 32'(exp));
    rd(3'd5);
    chk({rq, " sr read sel"}, 32'(dq_status_sel), 32'd1);
    chk({rq, " sr read data"}, 32'(dq_out), 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 rdy", 32'(rdy_o), 32'd1);
    chk("R1 sr_word", 32'(sr_word), 32'd0);
    rd(3'd0);
    chk("R1 sel", 32'(dq_status_sel), 32'd0);

    // R2 R4: program running, sweep sectors and data bit
    op_busy = 1; op_is_erase = 0;
    for (int i = 0; i < 32; i++) begin
      prog_d7 = i[1];
      poll_chk(SECT_W'(i), "R2 R4 program");
      chk("R2 rdy busy", 32'(rdy_o), 32'd0);
    end

    // R3 R4: erase running, every read sector against every erase sector
    op_is_erase = 1;
    for (int es = 0; es < 8; es++) begin
      erase_sector = SECT_W'(es);
      for (int s = 0; s < 8; s++) poll_chk(SECT_W'(s), "R3 R4 erase");
    end

    // R11 R4: erase suspended
    op_suspended = 1; erase_sector = 3'd2;
    for (int s = 0; s < 8; s++) poll_chk(SECT_W'(s), "R11 R4 esusp");
    chk("R11 rdy", 32'(rdy_o), 32'd1);
    pulse(6'b100000);
    sr_rd_chk(8'hC0, "R8 R11 esusp");
    rd(3'd0);
    chk("R8 mode exit", 32'(dq_status_sel), 32'd0);

    // R11: program suspended
    op_is_erase = 0;
    pulse(6'b100000);
    sr_rd_chk(8'h84, "R11 psusp");
    poll_chk(3'd2, "R11 psusp read");

    // R5: timeout during program
    op_suspended = 0; prog_d7 = 1;
    pulse(6'b000100);
    m_tmo = 1; op_busy = 0;
    chk("R5 rdy", 32'(rdy_o), 32'd0);
    poll_chk(3'd1, "R5 dq5");
    pulse(6'b100000);
    sr_rd_chk(8'h90, "R5 sr");
    pulse(6'b010000);
    chk("R9 clear sr", 32'(sr_word), 32'h80);
    chk("R5 clear keeps busy", 32'(rdy_o), 32'd0);
    poll_chk(3'd6, "R5 still held");
    pulse(6'b001000);
    m_tmo = 0;
    chk("R5 reset rdy", 32'(rdy_o), 32'd1);
    poll_chk(3'd6, "R5 after reset");

    // R6: buffer abort
    pulse(6'b000001);
    m_abort = 1;
    chk("R6 rdy", 32'(rdy_o), 32'd0);
    poll_chk(3'd4, "R6 dq1");
    pulse(6'b100000);
    sr_rd_chk(8'h98, "R6 sr");
    pulse(6'b010000);
    m_abort = 0;
    chk("R6 clear rdy", 32'(rdy_o), 32'd1);
    chk("R9 clear abort sr", 32'(sr_word), 32'h80);

    // R7: protection fault window
    pulse(6'b000010);
    for (int k = 0; k < PROTC; k++) begin
      chk("R7 busy window", 32'(rdy_o), 32'd0);
      @(negedge clk);
    end
    chk("R7 window end", 32'(rdy_o), 32'd1);
    pulse(6'b000010);
    pulse(6'b100000);
    chk("R7 invalid sr", 32'(sr_word), 32'h00);
    rd(3'd0);
    repeat (PROTC) @(negedge clk);
    pulse(6'b100000);
    sr_rd_chk(8'h82, "R7 lock bit");
    pulse(6'b010000);
    chk("R9 clear lock", 32'(sr_word), 32'h80);

    // R10: same-cycle capture and clear, same-cycle fault and clear
    pulse(6'b000001);
    pulse(6'b110000);
    chk("R10 capture wins", 32'(sr_word), 32'h98);
    chk("R10 flags cleared", 32'(rdy_o), 32'd1);
    rd(3'd0);
    pulse(6'b100000);
    sr_rd_chk(8'h80, "R10 recapture");
    pulse(6'b010001);
    chk("R10 event wins", 32'(rdy_o), 32'd0);
    pulse(6'b100000);
    sr_rd_chk(8'h98, "R10 event kept");
    pulse(6'b001000);
    chk("R9 reset clears", 32'(sr_word), 32'h80);
    chk("R6 reset releases", 32'(rdy_o), 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule